// File: doc/BRIEF.md
# Pulse-Width Single-Wire Frame Transmitter

This block sends one configuration frame to an external programmable device over a single line. A command is offered on a valid/ready interface. It carries a 2-bit function code, a 2-bit parameter selector and an 8-bit data value. On acceptance the block assembles a 38-bit frame and shifts it out most significant bit first. The frame holds a fixed opening marker, the function code, the selector, a fixed two-bit filler, the data byte and a fixed closing marker.

Each bit is a low-high-low pulse. Only the width of the high part carries the value: a short high is a zero and a long high is a one. All widths are given in microseconds and turned into clock cycles from the `CLK_HZ` parameter. The line is driven only while a frame is in flight and is released otherwise, so it can share a pin with an open-drain or tri-state pad.

Top module: `pw_frame_tx`

## Requirements
- R1: While reset is asserted and after it is released, `line_oe` and `line_o` are 0, `cmd_ready` is 1 and `done_o` is 0.
- R2: Frame bits 37..26 form the opening marker: one 1, then ten 0s, then one 1 (12'h801).
- R3: Bits 25..24 carry `cmd_func` MSB first. The codes pass through unchanged: 00 sense-current, 01 simulation, 10 fuse programming, 11 read.
- R4: Bits 23..22 carry `cmd_sel` MSB first. The codes are 00 second-stage gain, 01 first-stage gain, 10 output offset and 11 other functions.
- R5: Bits 21..20 are the fixed filler, a 1 followed by a 0.
- R6: Bits 19..12 carry `cmd_data`, most significant bit first.
- R7: Bits 11..0 form the closing marker: one 0, then ten 1s, then one 0 (12'h7FE).
- R8: Each bit drives the line low for CLK_HZ·10 µs, then high for CLK_HZ·5 µs (zero) or CLK_HZ·55 µs (one), then low again for CLK_HZ·10 µs. The cycle count is CLK_HZ·t/10^6.
- R9: `line_oe` is 1 from the cycle after acceptance until the last low interval of the closing marker ends, so for exactly the sum of the bit durations. The line is never high while `line_oe` is 0.
- R10: `cmd_ready` is low from the cycle after acceptance to the end of the frame. `done_o` is then high for exactly one cycle, in the first idle cycle, and `cmd_ready` is already 1 in that cycle.
- R11: A command held valid while busy is accepted when the current frame finishes. Back-to-back commands produce complete, separate frames.
- R12: The fields are captured at acceptance. Input changes after acceptance do not alter the frame in flight.
- R13: Reset during a frame releases the line at once and emits no `done_o`. The next command sends a full frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken on this cycle if valid |
| cmd_func | input | 2 | Function code |
| cmd_sel | input | 2 | Parameter selector |
| cmd_data | input | 8 | Data value |
| line_o | output | 1 | Line drive value |
| line_oe | output | 1 | Line drive enable (0 = released) |
| done_o | output | 1 | One-cycle pulse after a frame ends |

## Verification
The bench decodes the line with its own pulse-width decoder and rebuilds each frame from it. It drives commands that cover all four function codes and all four selector codes. The data bytes include all-zero, all-one, alternating patterns and single set bits, which expose field swaps, bit-order reversal and off-by-one shifts between fields. The all-ones and all-zero bytes also separate the long and short high widths, which is why the total busy length is compared against the value computed from the bits. Directed runs cover commands held off while busy, back-to-back frames, input changes during a frame, and reset in mid-frame.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    localparam int unsigned FUNC_W = 2;
    localparam int unsigned SEL_W  = 2;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned MARK_W = 12;
    localparam int unsigned FILL_W = 2;
    localparam int unsigned FRAME_W = 2 * MARK_W + FUNC_W + SEL_W + FILL_W + DATA_W;

    localparam logic [MARK_W-1:0] OPEN_MARK  = 12'h801;
    localparam logic [MARK_W-1:0] CLOSE_MARK = 12'h7FE;
    localparam logic [FILL_W-1:0] FILL_BITS  = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_HIGH  = 2'd2,
        PH_TRAIL = 2'd3
    } phase_e;

    function automatic int unsigned us_to_cycles(longint unsigned hz, int unsigned us);
        longint unsigned prod;
        prod = (hz * longint'(us)) / 64'd1_000_000;
        return 32'(prod);
    endfunction

endpackage

// File: rtl/pwt_frame_build.sv
module pwt_frame_build
    import pwt_pkg::*;
(
    input  logic [FUNC_W-1:0]  func_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [DATA_W-1:0]  data_i,
    output logic [FRAME_W-1:0] frame_o
);

    always_comb begin
        frame_o = {OPEN_MARK, func_i, sel_i, FILL_BITS, data_i, CLOSE_MARK};
    end

endmodule

// File: rtl/pwt_bit_timer.sv
module pwt_bit_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pwt_sequencer.sv
module pwt_sequencer
    import pwt_pkg::*;
#(
    parameter longint unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned     LOW_US  = 10,
    parameter int unsigned     ZERO_US = 5,
    parameter int unsigned     ONE_US  = 55
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               idle_o,
    output logic               line_o,
    output logic               line_oe_o,
    output logic               done_o
);

    localparam int unsigned LOW_CYC  = us_to_cycles(CLK_HZ, LOW_US);
    localparam int unsigned ZERO_CYC = us_to_cycles(CLK_HZ, ZERO_US);
    localparam int unsigned ONE_CYC  = us_to_cycles(CLK_HZ, ONE_US);
    localparam int unsigned MAX_CYC  = (ONE_CYC > LOW_CYC) ? ONE_CYC : LOW_CYC;
    localparam int unsigned CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam int unsigned IDX_W    = $clog2(FRAME_W);

    localparam logic [CNT_W-1:0] LOW_LD  = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] ZERO_LD = CNT_W'(ZERO_CYC - 1);
    localparam logic [CNT_W-1:0] ONE_LD  = CNT_W'(ONE_CYC - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        phase_e             phase;
        logic [FRAME_W-1:0] shreg;
        logic [IDX_W-1:0]   left;
        logic               line;
        logic               oe;
        logic               done;
    } seq_state_t;

    seq_state_t       st_d, st_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    pwt_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = LOW_LD;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_LEAD;
                    st_d.shreg = frame_i;
                    st_d.left  = LAST_IDX;
                    st_d.oe    = 1'b1;
                    st_d.line  = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = LOW_LD;
                end
            end
            PH_LEAD: begin
                if (tmr_expired) begin
                    st_d.phase = PH_HIGH;
                    st_d.line  = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = st_q.shreg[FRAME_W-1] ? ONE_LD : ZERO_LD;
                end
            end
            PH_HIGH: begin
                if (tmr_expired) begin
                    st_d.phase = PH_TRAIL;
                    st_d.line  = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = LOW_LD;
                end
            end
            PH_TRAIL: begin
                if (tmr_expired) begin
                    if (st_q.left == '0) begin
                        st_d.phase = PH_IDLE;
                        st_d.oe    = 1'b0;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.phase = PH_LEAD;
                        st_d.left  = st_q.left - 1'b1;
                        st_d.shreg = {st_q.shreg[FRAME_W-2:0], 1'b0};
                        tmr_load   = 1'b1;
                        tmr_val    = LOW_LD;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, shreg: '0, left: '0, line: 1'b0, oe: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign idle_o    = (st_q.phase == PH_IDLE);
    assign line_o    = st_q.line;
    assign line_oe_o = st_q.oe;
    assign done_o    = st_q.done;

endmodule

// File: rtl/pw_frame_tx.sv
module pw_frame_tx
    import pwt_pkg::*;
#(
    parameter longint unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned     LOW_US  = 10,
    parameter int unsigned     ZERO_US = 5,
    parameter int unsigned     ONE_US  = 55
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_func,
    input  logic [1:0]  cmd_sel,
    input  logic [7:0]  cmd_data,
    output logic        line_o,
    output logic        line_oe,
    output logic        done_o
);

    logic [FRAME_W-1:0] frame;
    logic               idle;
    logic               accept;

    pwt_frame_build u_build (
        .func_i  (cmd_func),
        .sel_i   (cmd_sel),
        .data_i  (cmd_data),
        .frame_o (frame)
    );

    assign accept = cmd_valid && idle;

    pwt_sequencer #(
        .CLK_HZ  (CLK_HZ),
        .LOW_US  (LOW_US),
        .ZERO_US (ZERO_US),
        .ONE_US  (ONE_US)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (accept),
        .frame_i   (frame),
        .idle_o    (idle),
        .line_o    (line_o),
        .line_oe_o (line_oe),
        .done_o    (done_o)
    );

    assign cmd_ready = idle;

endmodule

// File: rtl/pwt_tx_checker.sv
module pwt_tx_checker
    import pwt_pkg::*;
#(
    parameter longint unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned     ZERO_US = 5,
    parameter int unsigned     ONE_US  = 55
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic line_o,
    input logic line_oe,
    input logic done_o
);

    localparam int unsigned ZERO_CYC = us_to_cycles(CLK_HZ, ZERO_US);
    localparam int unsigned ONE_CYC  = us_to_cycles(CLK_HZ, ONE_US);

    int unsigned high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_run <= 0;
        end else if (line_o) begin
            high_run <= high_run + 1;
        end else begin
            high_run <= 0;
        end
    end

    // R8: every completed high interval has one of the two legal widths
    a_r8_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(line_o) && line_oe) |-> (high_run == ZERO_CYC || high_run == ONE_CYC));

    // R9: the line is high only while it is driven
    a_r9_high_only_driven: assert property (@(posedge clk) disable iff (!rst_n)
        line_o |-> line_oe);

    // R9: an idle block leaves the line released
    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !line_oe);

    // R10: completion is flagged only once idle again
    a_r10_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cmd_ready);

    // R10: completion pulse lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: an accepted command makes the block busy on the next cycle
    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

bind pw_frame_tx pwt_tx_checker #(
    .CLK_HZ  (CLK_HZ),
    .ZERO_US (ZERO_US),
    .ONE_US  (ONE_US)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .line_o    (line_o),
    .line_oe   (line_oe),
    .done_o    (done_o)
);

// File: tb/tb_pw_frame_tx.sv
`timescale 1ns/1ps
module tb_pw_frame_tx;

    localparam int LOW_C  = 10;
    localparam int ZERO_C = 5;
    localparam int ONE_C  = 55;
    localparam int THRESH = 30;
    localparam int NVEC   = 8;

    // {func, sel, data}
    localparam logic [11:0] VEC [NVEC] = '{
        {2'b00, 2'b00, 8'h00},
        {2'b01, 2'b01, 8'hFF},
        {2'b10, 2'b10, 8'hA5},
        {2'b11, 2'b11, 8'h5A},
        {2'b01, 2'b10, 8'h80},
        {2'b10, 2'b01, 8'h01},
        {2'b00, 2'b11, 8'h3C},
        {2'b11, 2'b00, 8'hC3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_func = '0;
    logic [1:0] cmd_sel = '0;
    logic [7:0] cmd_data = '0;
    logic       line_o, line_oe, done_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pw_frame_tx #(.CLK_HZ(1_000_000)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_func(cmd_func), .cmd_sel(cmd_sel), .cmd_data(cmd_data),
        .line_o(line_o), .line_oe(line_oe), .done_o(done_o)
    );

    // ---------------- pulse-width decoder ----------------
    logic [37:0] rx_word [16];
    int          rx_bits [16];
    logic        rx_bad  [16];
    int          rx_oe   [16];
    int          rx_rlo  [16];
    logic        rx_rdy  [16];
    int          rx_n = 0;
    logic        dbl_done = 1'b0;

    logic [37:0] m_bits;
    int m_hi, m_lo, m_n, m_oe, m_rlo;
    logic m_bad, prev_line, prev_done;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_bits = '0; m_hi = 0; m_lo = 0; m_n = 0; m_oe = 0; m_rlo = 0;
            m_bad = 1'b0; prev_line = 1'b0; prev_done = 1'b0;
        end else begin
            if (line_oe) m_oe++;
            if (!cmd_ready) m_rlo++;
            if (line_o) begin
                if (!prev_line) begin
                    if (m_lo != ((m_n == 0) ? LOW_C : 2 * LOW_C)) m_bad = 1'b1;
                    m_lo = 0;
                end
                m_hi++;
            end else begin
                if (prev_line) begin
                    if (m_hi != ZERO_C && m_hi != ONE_C) m_bad = 1'b1;
                    m_bits = {m_bits[36:0], (m_hi >= THRESH)};
                    m_n++;
                    m_hi = 0;
                end
                if (line_oe) m_lo++;
            end
            if (done_o && prev_done) dbl_done = 1'b1;
            if (done_o && rx_n < 16) begin
                if (m_lo != LOW_C) m_bad = 1'b1;
                rx_word[rx_n] = m_bits;
                rx_bits[rx_n] = m_n;
                rx_bad[rx_n]  = m_bad;
                rx_oe[rx_n]   = m_oe;
                rx_rlo[rx_n]  = m_rlo;
                rx_rdy[rx_n]  = cmd_ready;
                rx_n++;
                m_bits = '0; m_hi = 0; m_lo = 0; m_n = 0; m_oe = 0; m_rlo = 0; m_bad = 1'b0;
            end
            prev_line = line_o;
            prev_done = done_o;
        end
    end

    // ---------------- helpers ----------------
    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [37:0] exp_frame(input logic [1:0] f, input logic [1:0] s, input logic [7:0] d);
        return {12'h801, f, s, 2'b10, d, 12'h7FE};
    endfunction

    function automatic int exp_len(input logic [37:0] fr);
        int total = 0;
        for (int i = 0; i < 38; i++) total += 2 * LOW_C + (fr[i] ? ONE_C : ZERO_C);
        return total;
    endfunction

    task automatic push(input logic [1:0] f, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = f; cmd_sel = s; cmd_data = d;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        while (rx_n < n) @(negedge clk);
    endtask

    task automatic check_frame(input int idx, input logic [37:0] exp, input string tag);
        logic [37:0] got;
        got = rx_word[idx];
        chk(rx_bits[idx] == 38, {tag, " R9 bit count"}, 64'(rx_bits[idx]), 64'd38);
        chk(got[37:26] == exp[37:26], {tag, " R2 opening marker"}, 64'(got[37:26]), 64'(exp[37:26]));
        chk(got[25:24] == exp[25:24], {tag, " R3 function"}, 64'(got[25:24]), 64'(exp[25:24]));
        chk(got[23:22] == exp[23:22], {tag, " R4 selector"}, 64'(got[23:22]), 64'(exp[23:22]));
        chk(got[21:20] == exp[21:20], {tag, " R5 filler"}, 64'(got[21:20]), 64'(exp[21:20]));
        chk(got[19:12] == exp[19:12], {tag, " R6 data"}, 64'(got[19:12]), 64'(exp[19:12]));
        chk(got[11:0] == exp[11:0], {tag, " R7 closing marker"}, 64'(got[11:0]), 64'(exp[11:0]));
        chk(!rx_bad[idx], {tag, " R8 pulse widths"}, 64'(rx_bad[idx]), 64'd0);
        chk(rx_oe[idx] == exp_len(exp), {tag, " R9 drive length"}, 64'(rx_oe[idx]), 64'(exp_len(exp)));
        chk(rx_rlo[idx] == exp_len(exp), {tag, " R10 busy length"}, 64'(rx_rlo[idx]), 64'(exp_len(exp)));
        chk(rx_rdy[idx] == 1'b1, {tag, " R10 ready at done"}, 64'(rx_rdy[idx]), 64'd1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int base;
        logic [37:0] ea, eb;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!line_oe && !line_o && cmd_ready && !done_o, "R1 in reset",
            64'({line_oe, line_o, cmd_ready, done_o}), 64'b0010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!line_oe && !line_o && cmd_ready && !done_o, "R1 after reset",
            64'({line_oe, line_o, cmd_ready, done_o}), 64'b0010);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            base = rx_n;
            push(VEC[v][11:10], VEC[v][9:8], VEC[v][7:0]);
            wait_rx(base + 1);
            check_frame(base, exp_frame(VEC[v][11:10], VEC[v][9:8], VEC[v][7:0]), $sformatf("vec%0d", v));
            repeat (4) @(negedge clk);
        end

        // R11: back-to-back, second command held off while busy
        base = rx_n;
        ea = exp_frame(2'b01, 2'b00, 8'h96);
        eb = exp_frame(2'b10, 2'b11, 8'h69);
        push(2'b01, 2'b00, 8'h96);
        push(2'b10, 2'b11, 8'h69);
        wait_rx(base + 2);
        check_frame(base, ea, "R11 first");
        check_frame(base + 1, eb, "R11 second");
        chk(rx_word[base + 1] == eb, "R11 held command not dropped", 64'(rx_word[base + 1]), 64'(eb));

        // R12: inputs change during a frame
        repeat (4) @(negedge clk);
        base = rx_n;
        push(2'b11, 2'b01, 8'h0F);
        repeat (200) begin
            @(negedge clk);
            cmd_func = ~cmd_func; cmd_sel = ~cmd_sel; cmd_data = cmd_data + 8'd37;
        end
        wait_rx(base + 1);
        chk(rx_word[base] == exp_frame(2'b11, 2'b01, 8'h0F), "R12 captured fields",
            64'(rx_word[base]), 64'(exp_frame(2'b11, 2'b01, 8'h0F)));

        // R13: reset mid-frame
        repeat (4) @(negedge clk);
        base = rx_n;
        push(2'b00, 2'b10, 8'hFF);
        repeat (300) @(negedge clk);
        chk(line_oe && !cmd_ready, "R13 frame in flight", 64'({line_oe, cmd_ready}), 64'b10);
        rst_n = 1'b0;
        #1;
        chk(!line_oe && !line_o && cmd_ready, "R13 released in reset",
            64'({line_oe, line_o, cmd_ready}), 64'b001);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk(rx_n == base && !line_oe, "R13 no done after abort", 64'(rx_n), 64'(base));
        push(2'b11, 2'b10, 8'h42);
        wait_rx(base + 1);
        check_frame(base, exp_frame(2'b11, 2'b10, 8'h42), "R13 next");

        chk(!dbl_done, "R10 done single cycle", 64'(dbl_done), 64'd0);

        summary();
        $finish;
    end

endmodule